// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block interprets the stream of bus write cycles aimed at a byte-wide parallel NOR flash. Each completed write arrives as a one-cycle strobe with a 16-bit address and a data byte. The decoder walks the multi-write unlock sequences and keeps track of the device mode: array read, identifier read, unlock-bypass, or waiting on the program/erase engine. On a finished command it issues a one-cycle request to that engine: program (with the captured address and byte), chip erase, or abort.

Reads are not decoded here. The block only tells the read path which source to drive: the array, the identifier bytes or the engine status. It also supplies the identifier byte that matches the two low read address bits. A busy flag from the engine freezes command decoding until the operation ends. The only exception is the reset byte, which can still cancel a running chip erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), rd_sel is 0 (array), and prog_req, erase_req and abort_req are 0.
- R2: While idle, a write of F0h to any address returns the decoder to array read (rd_sel 0). This leaves identifier and bypass modes and drops any partial sequence. AA@555, 55@2AA, F0@555 has the same effect. The exception is the final data write of a program command.
- R3: AA@555, 55@2AA, 90@555 selects identifier read (rd_sel 1). That mode lasts until the next write. id_byte is 20h when rd_lo is 00 and 27h when rd_lo is 01, with any other rd_lo giving 00h.
- R4: AA@555, 55@2AA, A0@555 followed by any byte at any address raises prog_req for exactly one cycle, in the cycle after that fourth write. prog_addr and prog_data then hold that write's address and byte, whatever its value, including F0h.
- R5: AA@555, 55@2AA, 20@555 enters bypass mode. In that mode, A0h at any address followed by a byte at an address raises prog_req with that address and byte, and the decoder stays in bypass mode.
- R6: In bypass mode, 90h to any address followed by 00h to any address returns to array read. A following A0h plus data write produces no prog_req.
- R7: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 raises erase_req for one cycle after the sixth write. A wrong sixth write raises nothing.
- R8: Only wr_addr[10:0] is compared with 555h and 2AAh. Bits 15..11 have no effect on sequence matching.
- R9: A write that does not continue the sequence in progress abandons it and returns to array read (rd_sel 0). Later writes then start from the first unlock cycle.
- R10: While busy is 1, rd_sel is 2 (status) in the same cycle. Writes other than a cancelling F0h leave the mode unchanged. Once busy is 0 the read source is array or identifier again.
- R11: An F0h write while busy is 1 after a chip erase was requested raises abort_req for one cycle and returns to array read. F0h while busy after a program request raises no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse per completed bus write |
| wr_addr | input | 16 | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| busy | input | 1 | Program/erase engine running |
| rd_lo | input | 2 | Low two bits of the current read address |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte for rd_lo |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 16 | Address to program |
| prog_data | output | 8 | Byte to program |
| erase_req | output | 1 | One-cycle chip erase request |
| abort_req | output | 1 | One-cycle erase abort request |

## Verification
The bench drives each write strobe for one cycle between falling edges. The decoder takes the write at the next rising edge, so the request pulses and the new rd_sel both become visible after that edge. They are sampled at the following falling edge. Every request pulse is due exactly one cycle after its final write, and the bench also checks that it has gone one cycle later. rd_sel follows busy and id_byte follows rd_lo without a register, so those two are sampled one time step after the bench changes busy or rd_lo. A model in the bench steps on every write and supplies the expected values. The stimulus combines random command fragments with random upper address bits and directed sequences.

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CMD_AW = 11,
  parameter logic [CMD_AW-1:0] UNLOCK_A = 11'h555,
  parameter logic [CMD_AW-1:0] UNLOCK_B = 11'h2AA,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [1:0]        rd_lo,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] id_byte,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              abort_req
);
  localparam logic [DATA_W-1:0] K_AA = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] K_55 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] K_90 = DATA_W'(8'h90);
  localparam logic [DATA_W-1:0] K_A0 = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] K_20 = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] K_80 = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] K_10 = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] K_F0 = DATA_W'(8'hF0);
  localparam logic [DATA_W-1:0] K_00 = '0;
  localparam logic [1:0] SRC_ARRAY = 2'd0;
  localparam logic [1:0] SRC_ID    = 2'd1;
  localparam logic [1:0] SRC_STAT  = 2'd2;

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_PGM, S_ER3, S_ER4, S_ER5, S_BYP, S_BYP_PGM, S_BYP_RST
  } st_t;

  st_t  state, nxt;
  logic id_mode, id_nxt;
  logic erase_act, busy_q;
  logic preq, ereq, areq;

  wire at_a       = wr_addr[CMD_AW-1:0] == UNLOCK_A;
  wire at_b       = wr_addr[CMD_AW-1:0] == UNLOCK_B;
  wire data_phase = (state == S_PGM) || (state == S_BYP_PGM);
  wire rst_cmd    = wr_stb && (wr_data == K_F0) && !data_phase;

  always_comb begin
    nxt    = state;
    id_nxt = id_mode;
    preq   = 1'b0;
    ereq   = 1'b0;
    areq   = 1'b0;
    if (busy) begin
      if (rst_cmd && erase_act) begin
        nxt    = S_READ;
        id_nxt = 1'b0;
        areq   = 1'b1;
      end
    end else if (wr_stb) begin
      id_nxt = 1'b0;
      nxt    = S_READ;
      case (state)
        S_READ:    if (at_a && wr_data == K_AA) nxt = S_C1;
        S_C1:      if (at_b && wr_data == K_55) nxt = S_C2;
        S_C2:
          if (at_a) begin
            if (wr_data == K_90)      id_nxt = 1'b1;
            else if (wr_data == K_A0) nxt = S_PGM;
            else if (wr_data == K_20) nxt = S_BYP;
            else if (wr_data == K_80) nxt = S_ER3;
          end
        S_PGM:     preq = 1'b1;
        S_ER3:     if (at_a && wr_data == K_AA) nxt = S_ER4;
        S_ER4:     if (at_b && wr_data == K_55) nxt = S_ER5;
        S_ER5:     if (at_a && wr_data == K_10) ereq = 1'b1;
        S_BYP:
          if (wr_data == K_A0)      nxt = S_BYP_PGM;
          else if (wr_data == K_90) nxt = S_BYP_RST;
        S_BYP_PGM: begin
          preq = 1'b1;
          nxt  = S_BYP;
        end
        S_BYP_RST: if (wr_data == K_00) nxt = S_READ;
        default:   nxt = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_READ;
      id_mode   <= 1'b0;
      erase_act <= 1'b0;
      busy_q    <= 1'b0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      abort_req <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      state     <= nxt;
      id_mode   <= id_nxt;
      busy_q    <= busy;
      prog_req  <= preq;
      erase_req <= ereq;
      abort_req <= areq;
      if (preq) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ereq)                          erase_act <= 1'b1;
      else if (areq || (busy_q && !busy)) erase_act <= 1'b0;
    end
  end

  assign rd_sel  = busy ? SRC_STAT : (id_mode ? SRC_ID : SRC_ARRAY);
  assign id_byte = (rd_lo == 2'b00) ? MFR_CODE :
                   (rd_lo == 2'b01) ? DEV_CODE : '0;

  // R4
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  // R4
  prog_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(wr_stb) && prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));
  // R7
  erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ($past(state) == S_ER5 && !$past(busy)));
  // R11
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> ($past(busy) && $past(wr_stb) && $past(wr_data) == K_F0));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_data != K_F0) |=> ($stable(state) && $stable(id_mode)));
  // R1
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, wr_stb = 1'b0, busy = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_lo = '0;
  logic [1:0]  rd_sel;
  logic [7:0]  id_byte, prog_data;
  logic [15:0] prog_addr;
  logic        prog_req, erase_req, abort_req;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_lo(rd_lo), .rd_sel(rd_sel), .id_byte(id_byte),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .abort_req(abort_req));

  int checks = 0, errors = 0;
  localparam int M_READ = 0, M_C1 = 1, M_C2 = 2, M_PGM = 3, M_E3 = 4,
                 M_E4 = 5, M_E5 = 6, M_BYP = 7, M_BP = 8, M_BR = 9;
  int   m_st = M_READ;
  bit   m_id = 0, m_eact = 0;
  bit   e_prog, e_erase, e_abort;
  logic [15:0] e_pa;
  logic [7:0]  e_pd;

  function automatic logic [1:0] exp_src();
    return busy ? 2'd2 : (m_id ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [7:0] exp_id(input logic [1:0] lo);
    return lo == 2'b00 ? 8'h20 : (lo == 2'b01 ? 8'h27 : 8'h00);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] a, input logic [7:0] d);
    bit ua, ub;
    int prev;
    ua = (a[10:0] == 11'h555);
    ub = (a[10:0] == 11'h2AA);
    e_prog = 0; e_erase = 0; e_abort = 0;
    if (busy) begin
      if (d == 8'hF0 && m_st != M_PGM && m_st != M_BP && m_eact) begin
        e_abort = 1; m_eact = 0; m_st = M_READ; m_id = 0;
      end
      return;
    end
    prev = m_st;
    m_id = 0;
    m_st = M_READ;
    case (prev)
      M_READ: if (ua && d == 8'hAA) m_st = M_C1;
      M_C1:   if (ub && d == 8'h55) m_st = M_C2;
      M_C2: if (ua) begin
        if (d == 8'h90) m_id = 1;
        else if (d == 8'hA0) m_st = M_PGM;
        else if (d == 8'h20) m_st = M_BYP;
        else if (d == 8'h80) m_st = M_E3;
      end
      M_PGM: begin e_prog = 1; e_pa = a; e_pd = d; end
      M_E3: if (ua && d == 8'hAA) m_st = M_E4;
      M_E4: if (ub && d == 8'h55) m_st = M_E5;
      M_E5: if (ua && d == 8'h10) begin e_erase = 1; m_eact = 1; end
      M_BYP: if (d == 8'hA0) m_st = M_BP; else if (d == 8'h90) m_st = M_BR;
      M_BP: begin e_prog = 1; e_pa = a; e_pd = d; m_st = M_BYP; end
      default: m_st = M_READ;
    endcase
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    model(a, d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    check({tag, " rd_sel"}, 32'(rd_sel), 32'(exp_src()));
    check({tag, " prog_req"}, 32'(prog_req), 32'(e_prog));
    check({tag, " erase_req"}, 32'(erase_req), 32'(e_erase));
    check({tag, " abort_req"}, 32'(abort_req), 32'(e_abort));
    check("R3 id_byte", 32'(id_byte), 32'(exp_id(rd_lo)));
    if (e_prog) begin
      check({tag, " prog_addr"}, 32'(prog_addr), 32'(e_pa));
      check({tag, " prog_data"}, 32'(prog_data), 32'(e_pd));
    end
  endtask

  task automatic pulses_gone(input string tag);
    @(negedge clk);
    check({tag, " pulse width"}, 32'({prog_req, erase_req, abort_req}), 32'd0);
  endtask

  task automatic set_busy(input logic v);
    @(negedge clk);
    busy = v;
    #1;
    check("R10 rd_sel on busy", 32'(rd_sel), 32'(exp_src()));
    if (!v) m_eact = 0;
  endtask

  task automatic unlock(input logic [15:0] hi, input logic [7:0] cmd, input string tag);
    wr(hi | 16'h0555, 8'hAA, tag);
    wr(hi | 16'h02AA, 8'h55, tag);
    wr(hi | 16'h0555, cmd, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_sel", 32'(rd_sel), 32'd0);
    check("R1 pulses", 32'({prog_req, erase_req, abort_req}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_sel after release", 32'(rd_sel), 32'd0);

    // R3 identifier mode and codes
    unlock(16'h0000, 8'h90, "R3");
    check("R3 id mode", 32'(rd_sel), 32'd1);
    for (int i = 0; i < 4; i++) begin
      rd_lo = 2'(i);
      #1 check("R3 id_byte lo", 32'(id_byte), 32'(exp_id(2'(i))));
    end
    rd_lo = 2'b00;
    wr(16'h0000, 8'h00, "R9");
    // R8 upper bits ignored
    unlock(16'hF800, 8'h90, "R8");
    check("R8 id via high bits", 32'(rd_sel), 32'd1);
    wr(16'h1234, 8'hF0, "R2");
    // R2 three-write reset
    unlock(16'h0000, 8'h90, "R2");
    unlock(16'h0000, 8'hF0, "R2");
    check("R2 three-write reset", 32'(rd_sel), 32'd0);

    // R4 program, data byte F0
    unlock(16'h0000, 8'hA0, "R4");
    wr(16'h1234, 8'hF0, "R4");
    check("R4 prog_addr", 32'(prog_addr), 32'h1234);
    pulses_gone("R4");

    // R9 broken sequence
    wr(16'h0555, 8'hAA, "R9");
    wr(16'h02AB, 8'h55, "R9");
    wr(16'h0555, 8'hA0, "R9");
    wr(16'h4000, 8'h77, "R9");

    // R5 bypass program twice
    unlock(16'h0000, 8'h20, "R5");
    wr(16'h7000, 8'hA0, "R5");
    wr(16'h4321, 8'h3C, "R5");
    wr(16'h0000, 8'hA0, "R5");
    wr(16'h0FFF, 8'h5A, "R5");
    // R6 bypass exit
    wr(16'h0000, 8'h90, "R6");
    wr(16'h0000, 8'h00, "R6");
    wr(16'h0000, 8'hA0, "R6");
    wr(16'h0022, 8'h11, "R6");

    // R7 bad last write, then erase
    unlock(16'h0000, 8'h80, "R7");
    unlock(16'h0000, 8'h11, "R7");
    unlock(16'h0000, 8'h80, "R7");
    unlock(16'h3000, 8'h10, "R7");
    pulses_gone("R7");
    // R10 R11 abort during erase
    set_busy(1'b1);
    wr(16'h0555, 8'hAA, "R10");
    wr(16'h0000, 8'hF0, "R11");
    pulses_gone("R11");
    set_busy(1'b0);

    // R10 R11 program busy: writes ignored, F0 no abort
    unlock(16'h0000, 8'hA0, "R10");
    wr(16'h0100, 8'h42, "R10");
    set_busy(1'b1);
    wr(16'h0555, 8'hAA, "R10");
    wr(16'h0000, 8'hF0, "R11");
    set_busy(1'b0);
    wr(16'h02AA, 8'h55, "R10");
    wr(16'h0555, 8'h90, "R10");
    check("R10 AA ignored while busy", 32'(rd_sel), 32'd0);

    // random fragments
    void'($urandom(32'd1234));
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      rd_lo = 2'($urandom);
      case ($urandom % 10)
        0: begin a[10:0] = 11'h555; d = 8'hAA; end
        1: begin a[10:0] = 11'h2AA; d = 8'h55; end
        2: begin a[10:0] = 11'h555; d = 8'h90; end
        3: begin a[10:0] = 11'h555; d = 8'hA0; end
        4: begin a[10:0] = 11'h555; d = 8'h20; end
        5: begin a[10:0] = 11'h555; d = 8'h80; end
        6: begin a[10:0] = 11'h555; d = 8'h10; end
        7: d = 8'hF0;
        8: d = 8'h00;
        default: d = 8'($urandom);
      endcase
      wr(a, d, "R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule